// File: doc/BRIEF.md
# Step-Gated Interruptible Integer Divider

This block divides a 16-bit or 32-bit dividend by a 16-bit divisor. It returns a 16-bit quotient and a 16-bit remainder. A divide is a fixed run of 19 steps, and a step is taken only on a cycle where the step-enable input is high. This lets an enclosing loop sequencer issue one divide iteration per pass.

The operands are captured when the divide is started. Every value the divide depends on from then on lives in registers that the sequence updates in place. Raising the suspend input therefore freezes the divide between two steps for as long as needed. After suspend is released, the run finishes with the same result an unbroken run would give.

The 19 steps are used as follows:
- Step 1 turns the operands into magnitudes and flags a zero divisor or a high dividend half too large for a 16-bit quotient.
- Steps 2 to 17 each produce one quotient bit by restoring subtraction.
- Step 18 applies the quotient sign.
- Step 19 applies the remainder sign.

Top module: `iterDivider`

## Requirements
- R1: With `wideDiv`=0 and `signedDiv`=0, the low 16 bits of `dividend` are divided by `divisor` as unsigned numbers, and `quotient`/`remainder` hold the exact results in the cycle `done` is high.
- R2: With `wideDiv`=1 and `signedDiv`=0, the full 32-bit `dividend` is divided unsigned by `divisor`, and the quotient and remainder are exact when the quotient fits in 16 bits.
- R3: With `signedDiv`=1, the operands are two's complement (in 16-bit mode the dividend is the sign-extended low half). The quotient truncates toward zero and a nonzero remainder has the sign of the dividend.
- R4: A divide takes exactly 19 cycles with `stepEn`=1 after the start is accepted, and cycles with `stepEn`=0 do not advance it. `done` is high in the cycle after the 19th step and not before.
- R5: While `busy` is high, a cycle with `suspend`=1 takes no step, whatever `stepEn` is, and leaves `quotient`, `remainder` and `busy` unchanged. The result after resuming equals that of an uninterrupted run.
- R6: `busy` rises in the cycle after a start is accepted (`start`=1 while idle and `suspend`=0) and stays high up to the `done` cycle. `done` lasts exactly one cycle, with `busy` low during it.
- R7: A zero divisor sets `divZero`=1 at `done`, with `overflow`=0. `quotient` and `remainder` are then undefined.
- R8: `overflow` is 1 at `done` when the true quotient does not fit in 16 bits: above 0xFFFF unsigned, or outside -32768..32767 signed. This includes a 16-bit signed -32768 / -1.
- R9: `start` is ignored while `busy` is high, so the running divide finishes with its original operands.
- R10: After reset, `busy`, `done`, `divZero` and `overflow` are 0, and `quotient` and `remainder` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a divide with the present operands (accepted only while idle) |
| wideDiv | input | 1 | 1: 32-bit dividend, 0: 16-bit dividend in the low half |
| signedDiv | input | 1 | 1: two's-complement operands, 0: unsigned |
| dividend | input | 32 | Dividend |
| divisor | input | 16 | Divisor |
| stepEn | input | 1 | Take one divide step this cycle |
| suspend | input | 1 | Hold the divide state; overrides stepEn and start |
| quotient | output | 16 | Quotient (partial while busy) |
| remainder | output | 16 | Remainder (partial while busy) |
| busy | output | 1 | A divide is in progress |
| done | output | 1 | One-cycle pulse after the last step |
| divZero | output | 1 | Divisor was zero |
| overflow | output | 1 | Quotient does not fit in 16 bits |

## Verification
The divide is tried with both dividend widths and both sign modes:
- Small and all-ones unsigned operands show that every quotient bit position and the remainder path work.
- Sign combinations (negative by positive, positive by negative, negative by negative) separate quotient sign correction from remainder sign correction.
- Unsigned and signed wide divides beyond 16 quotient bits, and the signed -32768 / -1 case, tell the setup-time overflow check apart from the post-correction range check.
- Step-gap, suspended and start-while-busy runs must give the same results as plain runs, which shows that the step count, not cycle count, drives the sequence.

// File: rtl/divPkg.sv
package divPkg;

  // Strobes from the sequencer to the datapath; at most one is high per cycle.
  typedef struct packed {
    logic load;   // capture operands
    logic setup;  // magnitudes, flags
    logic iter;   // one restoring quotient bit
    logic fixQ;   // quotient sign
    logic fixR;   // remainder sign
  } divStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } divState_t;

endpackage

// File: rtl/divCtrl.sv
module divCtrl
  import divPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        stepEn,
  input  logic        suspend,
  output divStrobes_t stb,
  output logic        busy,
  output logic        done
);

  localparam int STEPS = DATA_W + 3;
  localparam int CNT_W = $clog2(STEPS);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(STEPS - 1);
  localparam logic [CNT_W-1:0] FIXQ_STEP = CNT_W'(STEPS - 2);
  localparam logic [CNT_W-1:0] ITER_LAST = CNT_W'(DATA_W);

  divState_t state;
  logic [CNT_W-1:0] stepCnt;
  logic advance;

  assign advance = (state == ST_RUN) && stepEn && !suspend;

  always_comb begin
    stb = '0;
    stb.load = (state == ST_IDLE) && start && !suspend;
    if (advance) begin
      if (stepCnt == '0)                                  stb.setup = 1'b1;
      else if (stepCnt <= ITER_LAST)                      stb.iter  = 1'b1;
      else if (stepCnt == FIXQ_STEP)                      stb.fixQ  = 1'b1;
      else                                                stb.fixR  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (stb.load) begin
          state   <= ST_RUN;
          stepCnt <= '0;
        end
        ST_RUN: if (advance) begin
          if (stepCnt == LAST_STEP) begin
            state   <= ST_DONE;
            stepCnt <= '0;
          end else begin
            stepCnt <= stepCnt + 1'b1;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state == ST_RUN);
  assign done = (state == ST_DONE);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done)); // R6
  AST_SUSPEND_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && suspend) |=> (busy && $stable(stepCnt))); // R5
  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    stepCnt <= LAST_STEP); // R4
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(stepCnt) == LAST_STEP)); // R4
  AST_BUSY_HOLDS_START: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (busy || done)); // R9

endmodule

// File: rtl/divDatapath.sv
module divDatapath
  import divPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  divStrobes_t           stb,
  input  logic                  wideIn,
  input  logic                  signedIn,
  input  logic [2*DATA_W-1:0]   dividendIn,
  input  logic [DATA_W-1:0]     divisorIn,
  output logic [DATA_W-1:0]     quotient,
  output logic [DATA_W-1:0]     remainder,
  output logic                  divZero,
  output logic                  overflow
);

  localparam int DW2 = 2 * DATA_W;
  localparam logic [DATA_W-1:0] SIGN_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DW2-1:0]    dvdReg;
  logic [DATA_W-1:0] dvsReg, dmagReg, remReg, quoReg;
  logic              wideReg, sgnReg, negQ, negR, zeroReg, ovfReg;

  logic [DW2-1:0]    extDvd, dvdMag;
  logic [DATA_W-1:0] dvsMag, diffLow;
  logic              dvdNeg, dvsNeg, fits;

  always_comb begin
    if (wideReg)     extDvd = dvdReg;
    else if (sgnReg) extDvd = {{DATA_W{dvdReg[DATA_W-1]}}, dvdReg[DATA_W-1:0]};
    else             extDvd = {{DATA_W{1'b0}}, dvdReg[DATA_W-1:0]};
    dvdNeg = sgnReg && extDvd[DW2-1];
    dvdMag = dvdNeg ? -extDvd : extDvd;
    dvsNeg = sgnReg && dvsReg[DATA_W-1];
    dvsMag = dvsNeg ? -dvsReg : dvsReg;
    // Restoring step: shift the next dividend bit into the partial remainder.
    fits    = {remReg, quoReg[DATA_W-1]} >= {1'b0, dmagReg};
    diffLow = {remReg[DATA_W-2:0], quoReg[DATA_W-1]} - dmagReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dvdReg <= '0; dvsReg <= '0; wideReg <= 1'b0; sgnReg <= 1'b0;
      dmagReg <= '0; remReg <= '0; quoReg <= '0;
      negQ <= 1'b0; negR <= 1'b0; zeroReg <= 1'b0; ovfReg <= 1'b0;
    end else begin
      if (stb.load) begin
        dvdReg  <= dividendIn;
        dvsReg  <= divisorIn;
        wideReg <= wideIn;
        sgnReg  <= signedIn;
        zeroReg <= 1'b0;
        ovfReg  <= 1'b0;
      end
      if (stb.setup) begin
        remReg  <= dvdMag[DW2-1:DATA_W];
        quoReg  <= dvdMag[DATA_W-1:0];
        dmagReg <= dvsMag;
        negQ    <= dvdNeg ^ dvsNeg;
        negR    <= dvdNeg;
        zeroReg <= (dvsMag == '0);
        ovfReg  <= (dvsMag != '0) && (dvdMag[DW2-1:DATA_W] >= dvsMag);
      end
      if (stb.iter) begin
        remReg <= fits ? diffLow : {remReg[DATA_W-2:0], quoReg[DATA_W-1]};
        quoReg <= {quoReg[DATA_W-2:0], fits};
      end
      if (stb.fixQ) begin
        quoReg <= negQ ? -quoReg : quoReg;
        if (sgnReg && !zeroReg &&
            (negQ ? (quoReg > SIGN_MIN) : quoReg[DATA_W-1]))
          ovfReg <= 1'b1;
      end
      if (stb.fixR)
        remReg <= negR ? -remReg : remReg;
    end
  end

  assign quotient  = quoReg;
  assign remainder = remReg;
  assign divZero   = zeroReg;
  assign overflow  = ovfReg;

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.setup || stb.iter || stb.fixQ || stb.fixR) |=>
      ($stable(quoReg) && $stable(remReg))); // R5
  AST_ZERO_NO_OVF: assert property (@(posedge clk) disable iff (!rstN)
    zeroReg |-> !ovfReg); // R7
  AST_OPERANDS_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> ($stable(dvdReg) && $stable(dvsReg))); // R9
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $countones(stb) <= 1); // R4

endmodule

// File: rtl/iterDivider.sv
module iterDivider
  import divPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                wideDiv,
  input  logic                signedDiv,
  input  logic [2*DATA_W-1:0] dividend,
  input  logic [DATA_W-1:0]   divisor,
  input  logic                stepEn,
  input  logic                suspend,
  output logic [DATA_W-1:0]   quotient,
  output logic [DATA_W-1:0]   remainder,
  output logic                busy,
  output logic                done,
  output logic                divZero,
  output logic                overflow
);

  divStrobes_t stb;

  divCtrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .stepEn(stepEn), .suspend(suspend),
    .stb(stb), .busy(busy), .done(done)
  );

  divDatapath #(.DATA_W(DATA_W)) i_datapath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .wideIn(wideDiv), .signedIn(signedDiv),
    .dividendIn(dividend), .divisorIn(divisor),
    .quotient(quotient), .remainder(remainder),
    .divZero(divZero), .overflow(overflow)
  );

endmodule

// File: tb/test_iterDivider.sv
module test_iterDivider;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0, wideDiv = 1'b0, signedDiv = 1'b0;
  logic [31:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic        stepEn = 1'b0, suspend = 1'b0;
  logic [15:0] quotient, remainder;
  logic        busy, done, divZero, overflow;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  iterDivider i_iterDivider (
    .clk(clk), .rstN(rstN), .start(start), .wideDiv(wideDiv), .signedDiv(signedDiv),
    .dividend(dividend), .divisor(divisor), .stepEn(stepEn), .suspend(suspend),
    .quotient(quotient), .remainder(remainder), .busy(busy), .done(done),
    .divZero(divZero), .overflow(overflow)
  );

  // {wide, signed, dividend[32], divisor[16], expQ[16], expR[16], expZero, expOvf}
  localparam int NV = 8;
  localparam logic [83:0] VEC [NV] = '{
    {1'b0, 1'b0, 32'd1000,       16'd7,      16'd142,    16'd6,      1'b0, 1'b0}, // R1
    {1'b0, 1'b0, 32'h0000FFFF,   16'd1,      16'hFFFF,   16'd0,      1'b0, 1'b0}, // R1
    {1'b0, 1'b0, 32'd5,          16'd9,      16'd0,      16'd5,      1'b0, 1'b0}, // R1
    {1'b1, 1'b0, 32'h00123456,   16'h1234,   16'h0100,   16'h0056,   1'b0, 1'b0}, // R2
    {1'b1, 1'b0, 32'hFFFE0001,   16'hFFFF,   16'hFFFF,   16'h0000,   1'b0, 1'b0}, // R2
    {1'b0, 1'b1, 32'h0000FFF9,   16'd2,      16'hFFFD,   16'hFFFF,   1'b0, 1'b0}, // R3
    {1'b0, 1'b1, 32'd7,          16'hFFFE,   16'hFFFD,   16'd1,      1'b0, 1'b0}, // R3
    {1'b1, 1'b1, 32'hFFFE7960,   16'hFFF9,   16'h37CD,   16'hFFFB,   1'b0, 1'b0}  // R3
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic startOp(input logic w, input logic s, input logic [31:0] dvd, input logic [15:0] dvs);
    wideDiv = w; signedDiv = s; dividend = dvd; divisor = dvs;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic giveSteps(input int n);
    stepEn = 1'b1;
    repeat (n) @(negedge clk);
    stepEn = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [15:0] holdQ, holdR;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy && !done, "R10 busy/done", {30'd0, busy, done}, 32'd0);
    chk(quotient == 0 && remainder == 0, "R10 results", {quotient, remainder}, 32'd0);
    chk(!divZero && !overflow, "R10 flags", {30'd0, divZero, overflow}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      startOp(VEC[i][83], VEC[i][82], VEC[i][81:50], VEC[i][49:34]);
      chk(busy, "R6 busy after start", {31'd0, busy}, 32'd1);
      giveSteps(18);
      chk(!done, "R4 no done before 19th step", {31'd0, done}, 32'd0);
      giveSteps(1);
      chk(done && !busy, "R6 done pulse", {30'd0, done, busy}, 32'd2);
      chk(quotient == VEC[i][33:18], "R1/R2/R3 quotient", {16'd0, quotient}, {16'd0, VEC[i][33:18]});
      chk(remainder == VEC[i][17:2], "R1/R2/R3 remainder", {16'd0, remainder}, {16'd0, VEC[i][17:2]});
      chk({divZero, overflow} == VEC[i][1:0], "R7/R8 flags", {30'd0, divZero, overflow}, {30'd0, VEC[i][1:0]});
      @(negedge clk);
      chk(!done, "R6 done lasts one cycle", {31'd0, done}, 32'd0);
    end

    // R4: steps separated by idle cycles still need exactly 19 steps
    startOp(1'b0, 1'b0, 32'd1000, 16'd7);
    for (int k = 0; k < 18; k++) begin
      stepEn = 1'b1; @(negedge clk);
      stepEn = 1'b0; @(negedge clk);
    end
    chk(!done && busy, "R4 gapped steps not finished", {30'd0, done, busy}, 32'd1);
    stepEn = 1'b1; @(negedge clk); stepEn = 1'b0;
    chk(done && quotient == 16'd142 && remainder == 16'd6, "R4 gapped result",
        {quotient, remainder}, {16'd142, 16'd6});

    // R5: suspend in the middle
    @(negedge clk);
    startOp(1'b1, 1'b0, 32'h00123456, 16'h1234);
    giveSteps(5);
    holdQ = quotient; holdR = remainder;
    suspend = 1'b1; stepEn = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(busy && quotient == holdQ && remainder == holdR, "R5 frozen while suspended",
          {quotient, remainder}, {holdQ, holdR});
    end
    stepEn = 1'b0; suspend = 1'b0;
    giveSteps(13);
    chk(!done, "R5 resume needs remaining steps", {31'd0, done}, 32'd0);
    giveSteps(1);
    chk(done && quotient == 16'h0100 && remainder == 16'h0056, "R5 resumed result",
        {quotient, remainder}, {16'h0100, 16'h0056});

    // R9: start while busy is ignored
    @(negedge clk);
    startOp(1'b0, 1'b0, 32'd1000, 16'd7);
    giveSteps(3);
    startOp(1'b0, 1'b0, 32'd5, 16'd9);
    giveSteps(15);
    chk(!done, "R9 no restart", {31'd0, done}, 32'd0);
    giveSteps(1);
    chk(done && quotient == 16'd142 && remainder == 16'd6, "R9 original operands kept",
        {quotient, remainder}, {16'd142, 16'd6});

    // R7: zero divisor
    @(negedge clk);
    startOp(1'b0, 1'b0, 32'd1234, 16'd0);
    giveSteps(19);
    chk(done && divZero && !overflow, "R7 zero divisor", {30'd0, divZero, overflow}, 32'd2);

    // R8: unsigned wide overflow
    @(negedge clk);
    startOp(1'b1, 1'b0, 32'h00010000, 16'd1);
    giveSteps(19);
    chk(done && overflow && !divZero, "R8 unsigned wide overflow", {31'd0, overflow}, 32'd1);

    // R8: signed -32768 / -1
    @(negedge clk);
    startOp(1'b0, 1'b1, 32'h00008000, 16'hFFFF);
    giveSteps(19);
    chk(done && overflow, "R8 signed min / -1", {31'd0, overflow}, 32'd1);

    // R8: signed -32768 / 1 fits
    @(negedge clk);
    startOp(1'b0, 1'b1, 32'h00008000, 16'd1);
    giveSteps(19);
    chk(done && !overflow && quotient == 16'h8000, "R8 signed min / 1 fits",
        {15'd0, overflow, quotient}, {16'd0, 16'h8000});

    @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule